// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. A single write-only control byte sets everything: transmit and receive enables, parity on/off, parity sense, transmit stop length and a three-bit baud source select. Both directions share one baud tick generator and one set of parity settings. The tick generator divides the core clock by one of a fixed set of ratios, or it forwards a tick input driven by an external timer. That tick runs at sixteen times the bit rate.

Software writes a byte into the one-entry transmit buffer through a strobe. The transmitter sends that byte once, as soon as transmission is enabled. Received bytes come out on a data bus with a one-clock valid pulse. Each received byte carries a parity-error flag and a framing-error flag. When a direction is disabled while its frame is in flight, the frame is allowed to finish first.

Top module: `sercomm_uart`

## Requirements
- R1: After reset the control byte is zero, `tx_line` is high, `tx_busy` is low and `rxd_valid` is low.
- R2: A transmitted frame is sent least significant bit first. It is a 0 start bit, 8 data bits, an optional parity bit, then stop bits at 1. The line idles high.
- R3: Control bit 3 set adds a parity bit after the data. Control bit 4 selects its sense: 1 means even parity (the count of ones in data plus parity is even), 0 means odd parity.
- R4: Control bit 5 selects the transmit stop length: 0 gives one stop bit, 1 gives two. Back-to-back frames therefore start 16·N·(bits per frame) clocks apart.
- R5: Control bits 2:0 pick the oversampling tick period in core clocks. 000=13, 001=26, 010=52, 011=104, 100=208, 101=416, 111=96. One bit lasts 16 ticks.
- R6: Select 110 takes one oversampling tick per clock that `ext_tick` is high. This tick serves both directions.
- R7: A control write leaves bits 2:0 unchanged whenever transmit (bit 7) or receive (bit 6) is enabled at the time of the write.
- R8: A frame starts only when a byte has been written since the last frame and bit 7 is set. A byte written while transmit is disabled is held and sent once transmit is enabled. Re-enabling transmit without a new write sends nothing.
- R9: Clearing bit 7 during a transmit frame lets that frame finish unchanged.
- R10: A receive frame starts only while bit 6 is set. Clearing bit 6 during a receive frame still delivers that byte.
- R11: The receiver samples each bit at its 8th tick. It drops a start bit that is high again at that sample.
- R12: On each received byte `rxd_valid` pulses for one clock with the byte. The parity-error flag is set on a parity mismatch, and the framing-error flag is set when the first stop bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte: [7] tx enable, [6] rx enable, [5] two stop bits, [4] even parity, [3] parity on, [2:0] baud select |
| ext_tick | input | 1 | External timer tick, used when baud select is 110 |
| txd_we | input | 1 | Transmit buffer write strobe |
| txd_data | input | 8 | Transmit buffer data |
| tx_line | output | 1 | Serial transmit line |
| tx_busy | output | 1 | High while a transmit frame is on the line |
| rx_line | input | 1 | Serial receive line |
| rxd_data | output | 8 | Last received byte |
| rxd_valid | output | 1 | One-clock pulse when `rxd_data` is loaded |
| rx_par_err | output | 1 | Parity error of the last received byte |
| rx_frm_err | output | 1 | Framing error of the last received byte |

## Verification
The bench measures the spacing of back-to-back frames. This exposes a wrong divide ratio, a wrong stop count or a missing parity slot as a frame that is too short or too long. It checks that a baud change is ignored while a direction is enabled: a design that accepted the change would produce a frame twice as long. It disables each direction in mid-frame. A design that obeyed at once would cut off the transmit frame or lose the received byte. It also re-enables transmit with an old byte in the buffer, where a wrong design would send that byte again. On the receive side it drives a start pulse too short to reach mid-bit, which a wrong design would take as a frame, and it drives bad parity and bad stop bits, which a wrong design would miss as errors.

// File: rtl/sercomm_pkg.sv
package sercomm_pkg;

  // control byte, msb first
  typedef struct packed {
    logic       txe;
    logic       rxe;
    logic       stop2;
    logic       even;
    logic       par_on;
    logic [2:0] brg;
  } ctl_t;

  typedef enum logic [2:0] {
    SRC_D1   = 3'd0,
    SRC_D2   = 3'd1,
    SRC_D4   = 3'd2,
    SRC_D8   = 3'd3,
    SRC_D16  = 3'd4,
    SRC_D32  = 3'd5,
    SRC_EXT  = 3'd6,
    SRC_ALT  = 3'd7
  } baud_src_e;

  localparam int DEF_OSR = 16;

endpackage

// File: rtl/sercomm_baud.sv
module sercomm_baud #(
  parameter int BASE_DIV = 13,
  parameter int ALT_DIV  = 96
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  input  logic       ext_tick,
  output logic       tick
);
  import sercomm_pkg::*;

  localparam int MAXDIV = (BASE_DIV * 32 > ALT_DIV) ? BASE_DIV * 32 : ALT_DIV;
  localparam int CW     = $clog2(MAXDIV + 1);

  logic [CW-1:0] div;
  logic [CW-1:0] cnt;

  // divider table computed by doubling the base ratio
  always_comb begin
    if (sel == SRC_ALT) div = CW'(ALT_DIV);
    else                div = CW'(BASE_DIV) << sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (sel == SRC_EXT) begin
      cnt  <= '0;
      tick <= ext_tick;
    end else if (cnt >= div - CW'(1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + CW'(1);
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/sercomm_tx.sv
module sercomm_tx #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          en,
  input  logic          stop2,
  input  logic          par_on,
  input  logic          par_even,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic          line,
  output logic          busy
);
  localparam int FW  = DW + 4;
  localparam int LW  = $clog2(FW + 1);
  localparam int TCW = $clog2(OSR);

  logic [DW-1:0]  hold;
  logic           pending;
  logic [FW-1:0]  sh;
  logic [FW-1:0]  frame;
  logic [LW-1:0]  left;
  logic [LW-1:0]  nbits;
  logic [TCW-1:0] tc;
  logic           start;

  always_comb begin
    frame         = '1;
    frame[0]      = 1'b0;
    frame[DW:1]   = hold;
    if (par_on) frame[DW+1] = par_even ? ^hold : ~^hold;
    nbits = LW'(DW + 2) + LW'(par_on) + LW'(stop2);
  end

  assign start = !busy && pending && en;
  assign line  = sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '1;
      busy    <= 1'b0;
      pending <= 1'b0;
      hold    <= '0;
      left    <= '0;
      tc      <= '0;
    end else begin
      if (start) begin
        sh      <= frame;
        left    <= nbits;
        tc      <= '0;
        busy    <= 1'b1;
        pending <= 1'b0;
      end else if (busy && tick) begin
        if (tc == TCW'(OSR - 1)) begin
          tc   <= '0;
          sh   <= {1'b1, sh[FW-1:1]};
          left <= left - LW'(1);
          if (left == LW'(1)) busy <= 1'b0;
        end else begin
          tc <= tc + TCW'(1);
        end
      end
      if (wr) begin
        hold    <= wdata;
        pending <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sercomm_rx.sv
module sercomm_rx #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          en,
  input  logic          par_on,
  input  logic          par_even,
  input  logic          line,
  output logic [DW-1:0] data,
  output logic          valid,
  output logic          par_err,
  output logic          frm_err,
  output logic          busy
);
  localparam int TCW = $clog2(OSR);
  localparam int IW  = $clog2(DW + 3);

  logic           s1, s2, prev;
  logic [TCW-1:0] tc;
  logic [IW-1:0]  idx;
  logic [IW-1:0]  stop_idx;
  logic [DW-1:0]  sh;
  logic           pe_l, ev_l, perr_l;
  logic           exp_par;

  assign stop_idx = IW'(DW + 1) + IW'(pe_l);
  assign exp_par  = ev_l ? ^sh : ~^sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1; s2 <= 1'b1; prev <= 1'b1;
      busy <= 1'b0; tc <= '0; idx <= '0; sh <= '0;
      pe_l <= 1'b0; ev_l <= 1'b0; perr_l <= 1'b0;
      data <= '0; valid <= 1'b0; par_err <= 1'b0; frm_err <= 1'b0;
    end else begin
      s1    <= line;
      s2    <= s1;
      prev  <= s2;
      valid <= 1'b0;
      if (!busy) begin
        if (en && prev && !s2) begin
          busy   <= 1'b1;
          tc     <= '0;
          idx    <= '0;
          pe_l   <= par_on;
          ev_l   <= par_even;
          perr_l <= 1'b0;
        end
      end else if (tick) begin
        if (tc == TCW'(OSR - 1)) begin
          tc  <= '0;
          idx <= idx + IW'(1);
        end else begin
          tc <= tc + TCW'(1);
        end
        if (tc == TCW'(OSR / 2 - 1)) begin
          if (idx == '0) begin
            if (s2) busy <= 1'b0;
          end else if (idx <= IW'(DW)) begin
            sh <= {s2, sh[DW-1:1]};
          end else if (idx < stop_idx) begin
            perr_l <= (s2 != exp_par);
          end else begin
            data    <= sh;
            valid   <= 1'b1;
            par_err <= perr_l;
            frm_err <= !s2;
            busy    <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/sercomm_uart.sv
module sercomm_uart #(
  parameter int DW       = 8,
  parameter int OSR      = sercomm_pkg::DEF_OSR,
  parameter int BASE_DIV = 13,
  parameter int ALT_DIV  = 96
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  input  logic          ext_tick,
  input  logic          txd_we,
  input  logic [DW-1:0] txd_data,
  output logic          tx_line,
  output logic          tx_busy,
  input  logic          rx_line,
  output logic [DW-1:0] rxd_data,
  output logic          rxd_valid,
  output logic          rx_par_err,
  output logic          rx_frm_err
);
  import sercomm_pkg::*;

  ctl_t       ctl_q;
  ctl_t       ctl_w;
  logic       tick;
  logic       en_tx, en_rx;
  logic [2:0] brg_sel;
  logic       rx_busy;

  assign ctl_w   = ctl_t'(cfg_wdata);
  assign en_tx   = ctl_q.txe;
  assign en_rx   = ctl_q.rxe;
  assign brg_sel = ctl_q.brg;

  // baud select is frozen while either direction is enabled
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (cfg_we) begin
      ctl_q.txe    <= ctl_w.txe;
      ctl_q.rxe    <= ctl_w.rxe;
      ctl_q.stop2  <= ctl_w.stop2;
      ctl_q.even   <= ctl_w.even;
      ctl_q.par_on <= ctl_w.par_on;
      if (!(ctl_q.txe || ctl_q.rxe)) ctl_q.brg <= ctl_w.brg;
    end
  end

  sercomm_baud #(.BASE_DIV(BASE_DIV), .ALT_DIV(ALT_DIV)) u_baud (
    .clk(clk), .rst(rst), .sel(brg_sel), .ext_tick(ext_tick), .tick(tick)
  );

  sercomm_tx #(.DW(DW), .OSR(OSR)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .en(en_tx),
    .stop2(ctl_q.stop2), .par_on(ctl_q.par_on), .par_even(ctl_q.even),
    .wr(txd_we), .wdata(txd_data), .line(tx_line), .busy(tx_busy)
  );

  sercomm_rx #(.DW(DW), .OSR(OSR)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .en(en_rx),
    .par_on(ctl_q.par_on), .par_even(ctl_q.even), .line(rx_line),
    .data(rxd_data), .valid(rxd_valid), .par_err(rx_par_err),
    .frm_err(rx_frm_err), .busy(rx_busy)
  );

endmodule

// File: rtl/sercomm_uart_chk.sv
module sercomm_uart_chk (
  input logic       clk,
  input logic       rst,
  input logic       en_tx,
  input logic       en_rx,
  input logic [2:0] brg_sel,
  input logic       tx_busy,
  input logic       tx_line,
  input logic       rx_busy,
  input logic       rxd_valid
);

  a_r7_brg_frozen: assert property (@(posedge clk) disable iff (rst)
    (en_tx || en_rx) |=> $stable(brg_sel));

  a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> tx_line);

  a_r8_tx_start_enabled: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_busy) |-> $past(en_tx));

  a_r10_rx_start_enabled: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_busy) |-> $past(en_rx));

  a_r12_valid_one_clock: assert property (@(posedge clk) disable iff (rst)
    rxd_valid |=> !rxd_valid);

endmodule

bind sercomm_uart sercomm_uart_chk u_chk (
  .clk(clk), .rst(rst), .en_tx(en_tx), .en_rx(en_rx), .brg_sel(brg_sel),
  .tx_busy(tx_busy), .tx_line(tx_line), .rx_busy(rx_busy), .rxd_valid(rxd_valid)
);

// File: tb/sercomm_uart_bench.sv
`timescale 1ns/1ps
module sercomm_uart_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       ext_tick = 1'b0;
  logic       txd_we = 1'b0;
  logic [7:0] txd_data = 8'h00;
  logic       tx_line, tx_busy;
  logic       rx_drv = 1'b1;
  logic [7:0] rxd_data;
  logic       rxd_valid, rx_par_err, rx_frm_err;

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  sercomm_uart u_sercomm_uart (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ext_tick(ext_tick), .txd_we(txd_we), .txd_data(txd_data),
    .tx_line(tx_line), .tx_busy(tx_busy), .rx_line(rx_drv),
    .rxd_data(rxd_data), .rxd_valid(rxd_valid),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;
  bit ext_done = 0;

  int         rx_cnt = 0;
  logic [7:0] rx_last = 8'h00;
  logic       rx_pe = 1'b0, rx_fe = 1'b0;
  always @(negedge clk) if (rxd_valid) begin
    rx_cnt  <= rx_cnt + 1;
    rx_last <= rxd_data;
    rx_pe   <= rx_par_err;
    rx_fe   <= rx_frm_err;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  function automatic logic [11:0] mk_frame(input logic [7:0] d, input bit pe, input bit ev);
    logic [11:0] f;
    f = '1;
    f[0] = 1'b0;
    f[8:1] = d;
    if (pe) f[9] = ev ? ^d : ~^d;
    return f;
  endfunction

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk); cfg_wdata = v; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic set_cfg(input logic [7:0] v);
    wr_cfg(8'h00);
    wr_cfg(v);
  endtask

  task automatic wr_tx(input logic [7:0] v);
    @(negedge clk); txd_data = v; txd_we = 1'b1;
    @(negedge clk); txd_we = 1'b0;
  endtask

  task automatic wait_busy(input logic lvl, input int lim, output bit ok);
    ok = 0;
    for (int i = 0; i < lim; i++) begin
      if (tx_busy == lvl) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic decode(input int div, input int nb, output logic [11:0] bits, output bit ok);
    int t0;
    bits = '1;
    ok = 0;
    for (int i = 0; i < 40000; i++) begin
      if (tx_line == 1'b0) begin ok = 1; break; end
      @(negedge clk);
    end
    t0 = cyc;
    if (ok) for (int k = 0; k < nb; k++) begin
      while (cyc < t0 + k * 16 * div + 8 * div) @(negedge clk);
      bits[k] = tx_line;
    end
  endtask

  task automatic spacing(input logic [7:0] a, input logic [7:0] b, output int sp);
    int t1;
    bit ok;
    wr_tx(a);
    wait_busy(1'b1, 100, ok);
    t1 = cyc;
    wr_tx(b);
    wait_busy(1'b0, 40000, ok);
    wait_busy(1'b1, 100, ok);
    sp = cyc - t1;
    wait_busy(1'b0, 40000, ok);
  endtask

  task automatic check_sp(input int sp, input int n, input int div, input string req);
    check(sp >= n * 16 * div - div - 1 && sp <= n * 16 * div + 3, req, sp, n * 16 * div);
  endtask

  task automatic send_bits(input logic [11:0] bits, input int nb, input int div);
    for (int k = 0; k < nb; k++) begin
      @(negedge clk);
      rx_drv = bits[k];
      repeat (16 * div - 1) @(negedge clk);
    end
    @(negedge clk);
    rx_drv = 1'b1;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(tx_line == 1'b1, "R1 tx_line", int'(tx_line), 1);
    check(tx_busy == 1'b0, "R1 tx_busy", int'(tx_busy), 0);
    check(rxd_valid == 1'b0, "R1 rxd_valid", int'(rxd_valid), 0);
  endtask

  task automatic t_held();
    logic [11:0] bits;
    bit ok;
    wr_tx(8'h5A);
    repeat (600) @(negedge clk);
    check(tx_busy == 1'b0 && tx_line == 1'b1, "R8 held while disabled (R1 ctl zero)", int'(tx_busy), 0);
    set_cfg(8'h80);
    decode(13, 10, bits, ok);
    check(ok && bits[9:0] == mk_frame(8'h5A, 0, 0)[9:0], "R8 held byte sent", int'(bits), int'(mk_frame(8'h5A, 0, 0)));
    wait_busy(1'b0, 40000, ok);
    wr_cfg(8'h00);
    wr_cfg(8'h80);
    wait_busy(1'b1, 3000, ok);
    check(!ok, "R8 no resend of stale byte", int'(ok), 0);
  endtask

  task automatic t_frame();
    logic [11:0] bits;
    bit ok;
    set_cfg(8'h80);
    wr_tx(8'hA5);
    decode(13, 10, bits, ok);
    check(ok && bits[9:0] == mk_frame(8'hA5, 0, 0)[9:0], "R2 frame A5", int'(bits[9:0]), int'(mk_frame(8'hA5, 0, 0)[9:0]));
    wait_busy(1'b0, 40000, ok);
    wr_tx(8'h3C);
    decode(13, 10, bits, ok);
    check(ok && bits[9:0] == mk_frame(8'h3C, 0, 0)[9:0], "R2 frame 3C", int'(bits[9:0]), int'(mk_frame(8'h3C, 0, 0)[9:0]));
    wait_busy(1'b0, 40000, ok);
  endtask

  task automatic t_parity();
    logic [11:0] bits;
    bit ok;
    set_cfg(8'h98);
    wr_tx(8'h07);
    decode(13, 11, bits, ok);
    check(ok && bits[10:0] == mk_frame(8'h07, 1, 1)[10:0], "R3 even parity", int'(bits[10:0]), int'(mk_frame(8'h07, 1, 1)[10:0]));
    wait_busy(1'b0, 40000, ok);
    set_cfg(8'h88);
    wr_tx(8'h07);
    decode(13, 11, bits, ok);
    check(ok && bits[10:0] == mk_frame(8'h07, 1, 0)[10:0], "R3 odd parity", int'(bits[10:0]), int'(mk_frame(8'h07, 1, 0)[10:0]));
    wait_busy(1'b0, 40000, ok);
  endtask

  task automatic t_stop();
    int sp;
    set_cfg(8'hA0);
    spacing(8'h12, 8'h34, sp);
    check_sp(sp, 11, 13, "R4 two stop bits");
    set_cfg(8'hB8);
    spacing(8'h56, 8'h78, sp);
    check_sp(sp, 12, 13, "R4 two stop bits with parity");
    set_cfg(8'h80);
    spacing(8'h9A, 8'hBC, sp);
    check_sp(sp, 10, 13, "R4 one stop bit");
  endtask

  task automatic t_lock();
    int sp;
    set_cfg(8'h80);
    wr_cfg(8'h81);
    spacing(8'h01, 8'h02, sp);
    check_sp(sp, 10, 13, "R7 baud change ignored while enabled");
    wr_cfg(8'h00);
    wr_cfg(8'h81);
    spacing(8'h03, 8'h04, sp);
    check_sp(sp, 10, 26, "R5 R7 select 001 applied when disabled");
  endtask

  task automatic t_baud();
    int sp;
    set_cfg(8'h87);
    spacing(8'h11, 8'h22, sp);
    check_sp(sp, 10, 96, "R5 select 111");
  endtask

  task automatic t_txdis();
    logic [11:0] bits;
    bit ok;
    set_cfg(8'h80);
    wr_tx(8'hC6);
    fork
      decode(13, 10, bits, ok);
      begin repeat (3 * 16 * 13) @(negedge clk); wr_cfg(8'h00); end
    join
    check(ok && bits[9:0] == mk_frame(8'hC6, 0, 0)[9:0], "R9 frame finishes after disable", int'(bits[9:0]), int'(mk_frame(8'hC6, 0, 0)[9:0]));
    wait_busy(1'b0, 40000, ok);
    wr_tx(8'h11);
    wait_busy(1'b1, 3000, ok);
    check(!ok && tx_line == 1'b1, "R9 disabled after frame", int'(ok), 0);
    wr_cfg(8'h80);
    decode(13, 10, bits, ok);
    check(ok && bits[9:0] == mk_frame(8'h11, 0, 0)[9:0], "R8 byte sent after enable", int'(bits[9:0]), int'(mk_frame(8'h11, 0, 0)[9:0]));
    wait_busy(1'b0, 40000, ok);
  endtask

  task automatic t_rx_basic();
    int c0;
    set_cfg(8'h40);
    c0 = rx_cnt;
    send_bits(mk_frame(8'h96, 0, 0), 10, 13);
    repeat (50) @(negedge clk);
    check(rx_cnt == c0 + 1 && rx_last == 8'h96, "R12 receive 96", int'(rx_last), 'h96);
    check(!rx_pe && !rx_fe, "R12 clean flags", int'({rx_pe, rx_fe}), 0);
    send_bits(mk_frame(8'h01, 0, 0), 10, 13);
    repeat (50) @(negedge clk);
    check(rx_cnt == c0 + 2 && rx_last == 8'h01, "R2 receive lsb first", int'(rx_last), 1);
  endtask

  task automatic t_rx_glitch();
    int c0;
    set_cfg(8'h40);
    c0 = rx_cnt;
    @(negedge clk); rx_drv = 1'b0;
    repeat (4 * 13) @(negedge clk);
    rx_drv = 1'b1;
    repeat (2500) @(negedge clk);
    check(rx_cnt == c0, "R11 short start rejected", rx_cnt - c0, 0);
    send_bits(mk_frame(8'h7E, 0, 0), 10, 13);
    repeat (50) @(negedge clk);
    check(rx_cnt == c0 + 1 && rx_last == 8'h7E, "R11 receive after glitch", int'(rx_last), 'h7E);
  endtask

  task automatic t_rx_err();
    logic [11:0] f;
    set_cfg(8'h58);
    send_bits(mk_frame(8'h0F, 1, 1), 11, 13);
    repeat (50) @(negedge clk);
    check(!rx_pe && rx_last == 8'h0F, "R12 good parity", int'(rx_pe), 0);
    f = mk_frame(8'h0F, 1, 1);
    f[9] = ~f[9];
    send_bits(f, 11, 13);
    repeat (50) @(negedge clk);
    check(rx_pe == 1'b1, "R12 parity error flagged", int'(rx_pe), 1);
    set_cfg(8'h40);
    f = mk_frame(8'hAA, 0, 0);
    f[9] = 1'b0;
    send_bits(f, 10, 13);
    repeat (50) @(negedge clk);
    check(rx_fe == 1'b1 && rx_last == 8'hAA, "R12 framing error flagged", int'(rx_fe), 1);
    send_bits(mk_frame(8'h55, 0, 0), 10, 13);
    repeat (50) @(negedge clk);
    check(rx_fe == 1'b0 && rx_last == 8'h55, "R12 framing flag clears", int'(rx_fe), 0);
  endtask

  task automatic t_rx_dis();
    int c0;
    set_cfg(8'h40);
    c0 = rx_cnt;
    fork
      send_bits(mk_frame(8'h5B, 0, 0), 10, 13);
      begin repeat (4 * 16 * 13) @(negedge clk); wr_cfg(8'h00); end
    join
    repeat (50) @(negedge clk);
    check(rx_cnt == c0 + 1 && rx_last == 8'h5B, "R10 frame delivered after disable", int'(rx_last), 'h5B);
    send_bits(mk_frame(8'h22, 0, 0), 10, 13);
    repeat (50) @(negedge clk);
    check(rx_cnt == c0 + 1, "R10 nothing received while disabled", rx_cnt - c0, 1);
  endtask

  task automatic t_ext();
    int sp;
    int c0;
    set_cfg(8'hC6);
    ext_done = 0;
    fork
      begin
        while (!ext_done) begin
          @(negedge clk);
          ext_tick = (cyc % 5 == 0);
        end
        ext_tick = 1'b0;
      end
      begin
        spacing(8'h33, 8'h44, sp);
        check_sp(sp, 10, 5, "R6 external tick transmit");
        c0 = rx_cnt;
        send_bits(mk_frame(8'h69, 0, 0), 10, 5);
        repeat (50) @(negedge clk);
        check(rx_cnt == c0 + 1 && rx_last == 8'h69, "R6 external tick receive", int'(rx_last), 'h69);
        ext_done = 1;
      end
    join
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_held();
    t_frame();
    t_parity();
    t_stop();
    t_lock();
    t_baud();
    t_txdis();
    t_rx_basic();
    t_rx_glitch();
    t_rx_err();
    t_rx_dis();
    t_ext();
    finish_up();
  end

  initial begin
    while (cyc < 195000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 195000);
    finish_up();
  end

endmodule